// File: doc/BRIEF.md
# Burst Payload Pseudo-Random Error Detector

This block checks a stream of byte-aligned received data against a locally generated pseudo-random pattern and counts bit errors. The received stream is bursty. Each burst carries a header, then a delimiter, then a payload whose length is known in advance. Bursts alternate between two sources, A and B, and each source has its own payload length. A small window machine opens after every delimiter and stays open for the right number of bytes. Only bytes inside that window are compared. Only those bytes advance the pattern and are counted.

The local generator is a linear recurrence chosen by a pattern-select input. It runs eight bits per clock. A synchronization machine watches the per-byte mismatch count. After a run of bad bytes it declares the pattern lost. It then reseeds the local history from the last 32 received payload bits and keeps doing so until a run of clean predictions shows it has locked again. Errors are accumulated only while locked.

An idle timer raises a no-signal flag when no delimiter has arrived for a programmable number of clocks. A synchronous clear zeroes both counters.

Top module: `burst_prbs_checker`

## Requirements
- R1: After reset both counters read zero, `in_sync_o` is low, `no_sig_o` is low for any nonzero limit, and the first window after reset uses length A.
- R2: A cycle with `dlm_det_i` high and no window open opens a window of the selected length; that cycle carries no payload. Window lengths alternate A, B, A, B starting from A. Only cycles with `byte_vld_i` high inside an open window are payload bytes. A delimiter while a window is open is ignored, and a zero length opens no window but still advances the alternation.
- R3: The byte counter increases by exactly one for each payload byte and for nothing else.
- R4: For each payload byte accepted while in sync, the error counter increases by the number of bit positions in which the received byte differs from the expected byte. Nothing is added while out of sync or for non-payload bytes.
- R5: `pat_sel_i` selects the recurrence b[n] = b[n-p] xor b[n-q], where 0 gives p=7,q=6; 1 gives p=15,q=14; 2 gives p=23,q=18; and 3 gives p=31,q=28. Bit 7 of each byte is the earliest bit, and the expected sequence advances only on payload bytes.
- R6: While in sync, 4 consecutive payload bytes that each have more than 2 bit errors drop sync. A payload byte with 2 or fewer errors restarts that run.
- R7: While out of sync, each prediction is built from the last 32 received payload bits. Sync is declared after 8 consecutive payload bytes predicted with zero errors. So after reset, sync stays low through the first 7 payload bytes and is high after 12 clean ones.
- R8: Both counters saturate at all ones (width `CNT_W`, 48 by default) instead of wrapping.
- R9: `cnt_clr_i` zeroes both counters at the next clock edge, overrides a same-cycle increment, and leaves the sync state untouched.
- R10: `no_sig_o` is high when the number of clocks since the last delimiter (or since reset) is at least `nosig_lim_i`. It goes low one clock after any delimiter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive byte clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| rx_byte_i | input | BYTE_W | Aligned received byte, bit 7 earliest |
| byte_vld_i | input | 1 | Received byte present this cycle |
| dlm_det_i | input | 1 | Delimiter found this cycle |
| len_a_i | input | LEN_W | Payload length in bytes for source A bursts |
| len_b_i | input | LEN_W | Payload length in bytes for source B bursts |
| pat_sel_i | input | 2 | Recurrence selection |
| cnt_clr_i | input | 1 | Synchronous clear of both counters |
| nosig_lim_i | input | TMR_W | Clocks without a delimiter before no-signal |
| err_cnt_o | output | CNT_W | Accumulated bit errors |
| byte_cnt_o | output | CNT_W | Accumulated payload bytes |
| in_sync_o | output | 1 | Local pattern locked to received data |
| no_sig_o | output | 1 | No delimiter within the limit |

## Verification
A window opened with the wrong length shows up within one burst. Either padding bytes are counted or payload bytes are missed, so the byte count drifts, and the pattern misaligns and errors jump. A wrong tap, bit order or reseed leaves `in_sync_o` low after twelve clean bytes, or produces error counts that do not match the injected masks at the next payload byte. Wrong run thresholds move the exact payload byte on which sync drops, and the bench watches that byte directly.

// File: rtl/berr_pkg.sv
package berr_pkg;

  localparam int SEED_W = 32;

  typedef enum logic [1:0] {
    PAT_P7  = 2'd0,
    PAT_P15 = 2'd1,
    PAT_P23 = 2'd2,
    PAT_P31 = 2'd3
  } pat_e;

  typedef enum logic {
    WIN_IDLE = 1'b0,
    WIN_PAY  = 1'b1
  } win_e;

  typedef enum logic {
    SY_HUNT = 1'b0,
    SY_LOCK = 1'b1
  } sync_e;

  // history bit k holds the bit received k steps ago (k = 0 newest)
  function automatic logic [SEED_W-1:0] pat_taps(input pat_e p);
    logic [SEED_W-1:0] m;
    case (p)
      PAT_P7:  m = 32'h0000_0060;
      PAT_P15: m = 32'h0000_6000;
      PAT_P23: m = 32'h0042_0000;
      default: m = 32'h4800_0000;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/berr_window.sv
module berr_window
  import berr_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             byte_vld_i,
  input  logic             dlm_i,
  input  logic [LEN_W-1:0] len_a_i,
  input  logic [LEN_W-1:0] len_b_i,
  output logic             pay_o
);

  win_e             st_q, st_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             sel_q, sel_d;
  logic [LEN_W-1:0] len_sel;

  always_comb begin
    len_sel = sel_q ? len_b_i : len_a_i;
    st_d    = st_q;
    rem_d   = rem_q;
    sel_d   = sel_q;
    case (st_q)
      WIN_IDLE: begin
        if (dlm_i) begin
          sel_d = ~sel_q;
          if (len_sel != '0) begin
            st_d  = WIN_PAY;
            rem_d = len_sel;
          end
        end
      end
      WIN_PAY: begin
        if (byte_vld_i) begin
          rem_d = rem_q - 1'b1;
          if (rem_q == LEN_W'(1)) st_d = WIN_IDLE;
        end
      end
      default: st_d = WIN_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= WIN_IDLE;
      rem_q <= '0;
      sel_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
      sel_q <= sel_d;
    end
  end

  assign pay_o = (st_q == WIN_PAY) && byte_vld_i;

  // R2: an open window without a byte keeps its remaining length even if a delimiter arrives
  assert_win_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == WIN_PAY && !byte_vld_i) |=> (st_q == WIN_PAY && $stable(rem_q)));

endmodule

// File: rtl/berr_track.sv
module berr_track
  import berr_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int LOSS_RUN = 4,
  parameter int LOSS_THR = 2,
  parameter int LOCK_RUN = 8,
  localparam int NERR_W  = $clog2(BYTE_W + 1),
  localparam int RUN_MAX = (LOSS_RUN > LOCK_RUN) ? LOSS_RUN : LOCK_RUN,
  localparam int RUN_W   = $clog2(RUN_MAX + 1),
  localparam int KEEP_W  = SEED_W - BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              pay_i,
  input  logic [BYTE_W-1:0] rx_i,
  input  pat_e              pat_i,
  output logic [NERR_W-1:0] nerr_o,
  output logic              chk_o,
  output logic              locked_o
);

  sync_e             st_q, st_d;
  logic [RUN_W-1:0]  run_q, run_d;
  logic [SEED_W-1:0] loc_q, loc_d;
  logic [KEEP_W-1:0] rxh_q, rxh_d;
  logic [SEED_W-1:0] mask;
  logic [SEED_W-1:0] seed;
  logic [BYTE_W-1:0] expv;
  logic [NERR_W-1:0] nerr;

  function automatic logic [BYTE_W-1:0] gen_byte(input logic [SEED_W-1:0] h,
                                                  input logic [SEED_W-1:0] m);
    logic [SEED_W-1:0] s;
    logic [BYTE_W-1:0] r;
    logic              b;
    s = h;
    r = '0;
    for (int i = 0; i < BYTE_W; i++) begin
      b = ^(s & m);
      s = {s[SEED_W-2:0], b};
      r[BYTE_W-1-i] = b;
    end
    return r;
  endfunction

  always_comb begin
    mask  = pat_taps(pat_i);
    expv  = gen_byte(loc_q, mask);
    nerr  = NERR_W'($countones(expv ^ rx_i));
    seed  = {rxh_q, rx_i};
    st_d  = st_q;
    run_d = run_q;
    loc_d = loc_q;
    rxh_d = rxh_q;
    if (pay_i) begin
      rxh_d = seed[KEEP_W-1:0];
      case (st_q)
        SY_LOCK: begin
          loc_d = {loc_q[KEEP_W-1:0], expv};
          if (nerr > NERR_W'(LOSS_THR)) begin
            if (run_q == RUN_W'(LOSS_RUN - 1)) begin
              st_d  = SY_HUNT;
              run_d = '0;
              loc_d = seed;
            end else begin
              run_d = run_q + 1'b1;
            end
          end else begin
            run_d = '0;
          end
        end
        default: begin
          loc_d = seed;
          if (nerr == '0) begin
            if (run_q == RUN_W'(LOCK_RUN - 1)) begin
              st_d  = SY_LOCK;
              run_d = '0;
            end else begin
              run_d = run_q + 1'b1;
            end
          end else begin
            run_d = '0;
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= SY_HUNT;
      run_q <= '0;
      loc_q <= '0;
      rxh_q <= '0;
    end else begin
      st_q  <= st_d;
      run_q <= run_d;
      loc_q <= loc_d;
      rxh_q <= rxh_d;
    end
  end

  assign nerr_o   = nerr;
  assign locked_o = (st_q == SY_LOCK);
  assign chk_o    = pay_i && locked_o;

  // R7: lock is only gained on a clean payload byte
  assert_lock_gain_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(locked_o) |-> $past(pay_i && nerr_o == '0));

  // R7: a mismatching byte while hunting keeps the block out of sync
  assert_hunt_stay_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!locked_o && pay_i && nerr_o != '0) |=> !locked_o);

  // R6: lock is only dropped on a payload byte above the error threshold
  assert_lock_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(locked_o) |-> $past(pay_i && nerr_o > NERR_W'(LOSS_THR)));

endmodule

// File: rtl/berr_satcnt.sv
module berr_satcnt #(
  parameter int CNT_W = 48,
  parameter int INC_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [INC_W-1:0] inc_i,
  output logic [CNT_W-1:0] cnt_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [CNT_W:0]   sum;

  always_comb begin
    sum   = {1'b0, cnt_q} + (CNT_W + 1)'(inc_i);
    cnt_d = cnt_q;
    if (clr_i) begin
      cnt_d = '0;
    end else if (en_i) begin
      cnt_d = sum[CNT_W] ? {CNT_W{1'b1}} : sum[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  // R8: without a clear the count never decreases (no wrap)
  assert_no_wrap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_i |=> (cnt_o >= $past(cnt_o)));

  // R9: a clear leaves zero behind
  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_o == '0));

endmodule

// File: rtl/berr_idle.sv
module berr_idle #(
  parameter int TMR_W = 24
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             dlm_i,
  input  logic [TMR_W-1:0] lim_i,
  output logic             nosig_o
);

  logic [TMR_W-1:0] idle_q, idle_d;

  always_comb begin
    idle_d = idle_q;
    if (dlm_i)                       idle_d = '0;
    else if (idle_q != {TMR_W{1'b1}}) idle_d = idle_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) idle_q <= '0;
    else         idle_q <= idle_d;
  end

  assign nosig_o = (idle_q >= lim_i);

  // R10: a delimiter removes the no-signal flag on the next cycle
  assert_dlm_clears_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dlm_i |=> (!nosig_o || lim_i == '0));

endmodule

// File: rtl/burst_prbs_checker.sv
module burst_prbs_checker
  import berr_pkg::*;
#(
  parameter int BYTE_W   = 8,
  parameter int LEN_W    = 16,
  parameter int CNT_W    = 48,
  parameter int TMR_W    = 24,
  parameter int LOSS_RUN = 4,
  parameter int LOSS_THR = 2,
  parameter int LOCK_RUN = 8,
  localparam int NERR_W  = $clog2(BYTE_W + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BYTE_W-1:0] rx_byte_i,
  input  logic              byte_vld_i,
  input  logic              dlm_det_i,
  input  logic [LEN_W-1:0]  len_a_i,
  input  logic [LEN_W-1:0]  len_b_i,
  input  logic [1:0]        pat_sel_i,
  input  logic              cnt_clr_i,
  input  logic [TMR_W-1:0]  nosig_lim_i,
  output logic [CNT_W-1:0]  err_cnt_o,
  output logic [CNT_W-1:0]  byte_cnt_o,
  output logic              in_sync_o,
  output logic              no_sig_o
);

  logic [1:0]        rst_sync_q;
  logic              rst_n;
  logic              pay;
  logic              chk;
  logic [NERR_W-1:0] nerr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sync_q <= 2'b00;
    else         rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n = rst_sync_q[1];

  berr_window #(.LEN_W(LEN_W)) win_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .byte_vld_i (byte_vld_i),
    .dlm_i      (dlm_det_i),
    .len_a_i    (len_a_i),
    .len_b_i    (len_b_i),
    .pay_o      (pay)
  );

  berr_track #(
    .BYTE_W   (BYTE_W),
    .LOSS_RUN (LOSS_RUN),
    .LOSS_THR (LOSS_THR),
    .LOCK_RUN (LOCK_RUN)
  ) trk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .pay_i    (pay),
    .rx_i     (rx_byte_i),
    .pat_i    (pat_e'(pat_sel_i)),
    .nerr_o   (nerr),
    .chk_o    (chk),
    .locked_o (in_sync_o)
  );

  berr_satcnt #(.CNT_W(CNT_W), .INC_W(NERR_W)) errc_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .clr_i  (cnt_clr_i),
    .en_i   (chk),
    .inc_i  (nerr),
    .cnt_o  (err_cnt_o)
  );

  berr_satcnt #(.CNT_W(CNT_W), .INC_W(1)) bytc_i (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .clr_i  (cnt_clr_i),
    .en_i   (pay),
    .inc_i  (1'b1),
    .cnt_o  (byte_cnt_o)
  );

  berr_idle #(.TMR_W(TMR_W)) idle_i (
    .clk_i   (clk_i),
    .rst_ni  (rst_n),
    .dlm_i   (dlm_det_i),
    .lim_i   (nosig_lim_i),
    .nosig_o (no_sig_o)
  );

endmodule

// File: tb/burst_prbs_checker_tb_top.sv
`timescale 1ns/1ps
module burst_prbs_checker_tb_top;

  localparam int CW  = 8;
  localparam int LA  = 6;
  localparam int LB  = 10;
  localparam int LIM = 40;
  localparam longint CMAX = 255;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] rx_byte;
  logic       byte_vld;
  logic       dlm;
  logic [1:0] pat;
  logic       clr;
  logic [CW-1:0] err_cnt, byte_cnt;
  logic       in_sync, no_sig;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  logic [31:0] q;
  int  bpat;
  int  remaining;
  bit  pkt_b;
  longint exp_err, exp_byt;

  always #4 clk = ~clk;

  burst_prbs_checker #(
    .BYTE_W(8), .LEN_W(8), .CNT_W(CW), .TMR_W(8)
  ) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .rx_byte_i(rx_byte), .byte_vld_i(byte_vld),
    .dlm_det_i(dlm), .len_a_i(8'(LA)), .len_b_i(8'(LB)), .pat_sel_i(pat),
    .cnt_clr_i(clr), .nosig_lim_i(8'(LIM)), .err_cnt_o(err_cnt),
    .byte_cnt_o(byte_cnt), .in_sync_o(in_sync), .no_sig_o(no_sig)
  );

  task automatic chk(input string what, input longint act, input longint expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, expv);
    end
  endtask

  task automatic step(input logic [7:0] d, input logic v, input logic dl);
    @(negedge clk);
    rx_byte  = d;
    byte_vld = v;
    dlm      = dl;
    @(posedge clk);
    #1;
  endtask

  function automatic longint sat(input longint x);
    return (x > CMAX) ? CMAX : x;
  endfunction

  task automatic gen_tx(output logic [7:0] b);
    int o, t;
    logic nb;
    o = 7 + 8 * bpat;
    case (bpat)
      0: t = 6;
      1: t = 14;
      2: t = 18;
      default: t = 28;
    endcase
    for (int i = 0; i < 8; i++) begin
      nb = q[o-1] ^ q[t-1];
      q  = {q[30:0], nb};
      b[7-i] = nb;
    end
  endtask

  task automatic start_pkt();
    step(8'h00, 1'b0, 1'b1);
    remaining = pkt_b ? LB : LA;
    pkt_b = !pkt_b;
  endtask

  task automatic pay(input logic [7:0] m, input bit ce);
    logic [7:0] b;
    if (remaining == 0) begin
      step(8'hC3, 1'b1, 1'b0);
      step(8'h3C, 1'b1, 1'b0);
      start_pkt();
    end
    gen_tx(b);
    step(b ^ m, 1'b1, 1'b0);
    remaining--;
    exp_byt = sat(exp_byt + 1);
    if (ce) exp_err = sat(exp_err + $countones(m));
  endtask

  task automatic finish_pkt();
    while (remaining > 0) pay(8'h00, 1'b1);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(8'h00, 1'b0, 1'b0);
    step(8'h00, 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (3) step(8'h00, 1'b0, 1'b0);
    remaining = 0;
    pkt_b = 1'b0;
    exp_err = 0;
    exp_byt = 0;
    q = 32'h1F2E_3D4C;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rx_byte = 8'h00; byte_vld = 1'b0; dlm = 1'b0; clr = 1'b0; pat = 2'd0;
    bpat = 0;
    do_reset();
    // R1: reset state
    chk("R1 err after reset", err_cnt, 0);
    chk("R1 bytes after reset", byte_cnt, 0);
    chk("R1 sync after reset", in_sync, 0);
    chk("R1 nosig after reset", no_sig, 0);

    // R5 and R7: every pattern, lock timing from reset
    for (int p = 0; p < 4; p++) begin
      pat = 2'(p);
      bpat = p;
      do_reset();
      repeat (7) pay(8'h00, 1'b0);
      chk($sformatf("R7 no lock after 7 pat%0d", p), in_sync, 0);
      repeat (5) pay(8'h00, 1'b0);
      chk($sformatf("R5 R7 locked after 12 pat%0d", p), in_sync, 1);
      chk($sformatf("R4 no errors pat%0d", p), err_cnt, exp_err);
      chk($sformatf("R3 R1 bytes pat%0d", p), byte_cnt, exp_byt);
    end

    // R4 and R6: error injection while locked (pattern 3)
    pay(8'h01, 1'b1);
    pay(8'h81, 1'b1);
    pay(8'h00, 1'b1);
    chk("R4 popcount sum", err_cnt, exp_err);
    repeat (3) pay(8'h07, 1'b1);
    pay(8'h03, 1'b1);
    repeat (3) pay(8'h07, 1'b1);
    chk("R6 run restarted keeps lock", in_sync, 1);
    chk("R4 heavy errors counted", err_cnt, exp_err);
    pay(8'h07, 1'b1);
    chk("R6 lock lost on 4th bad byte", in_sync, 0);
    chk("R4 4th bad byte counted", err_cnt, exp_err);
    repeat (4) pay(8'hFF, 1'b0);
    chk("R4 no counting out of sync", err_cnt, exp_err);
    repeat (12) pay(8'h00, 1'b0);
    chk("R7 relock after reseed", in_sync, 1);
    chk("R3 bytes across loss", byte_cnt, exp_byt);

    // R2 and R5: bytes outside windows are ignored
    finish_pkt();
    repeat (5) step(8'hA5, 1'b1, 1'b0);
    chk("R3 outside bytes not counted", byte_cnt, exp_byt);
    chk("R4 outside bytes no errors", err_cnt, exp_err);
    repeat (3) pay(8'h00, 1'b1);
    chk("R5 pattern held outside window", in_sync, 1);
    chk("R5 no spurious errors", err_cnt, exp_err);
    finish_pkt();
    pay(8'h00, 1'b1);
    repeat (3) step(8'h00, 1'b0, 1'b0);
    step(8'h5A, 1'b0, 1'b1);
    finish_pkt();
    step(8'h99, 1'b1, 1'b0);
    step(8'h66, 1'b1, 1'b0);
    chk("R2 delimiter in window ignored", byte_cnt, exp_byt);
    chk("R2 alignment kept", err_cnt, exp_err);
    pay(8'h00, 1'b1);
    pay(8'h00, 1'b1);
    chk("R2 alternation keeps lock", in_sync, 1);

    // R9: clear
    clr = 1'b1;
    pay(8'h00, 1'b1);
    clr = 1'b0;
    exp_err = 0;
    exp_byt = 0;
    chk("R9 clear bytes", byte_cnt, 0);
    chk("R9 clear errors", err_cnt, 0);
    chk("R9 sync kept", in_sync, 1);
    pay(8'h01, 1'b1);
    chk("R9 counting resumes", err_cnt, exp_err);

    // R10: no-signal timer
    finish_pkt();
    start_pkt();
    repeat (LIM - 1) step(8'h00, 1'b0, 1'b0);
    chk("R10 below limit", no_sig, 0);
    step(8'h00, 1'b0, 1'b0);
    chk("R10 at limit", no_sig, 1);
    step(8'h00, 1'b0, 1'b1);
    chk("R10 delimiter drops flag", no_sig, 0);

    // R5: wrong recurrence never locks
    pat = 2'd0;
    bpat = 3;
    do_reset();
    repeat (20) pay(8'h00, 1'b0);
    chk("R5 wrong pattern stays unlocked", in_sync, 0);
    chk("R3 bytes wrong pattern", byte_cnt, exp_byt);

    // R8: saturation
    pat = 2'd3;
    bpat = 3;
    do_reset();
    repeat (12) pay(8'h00, 1'b0);
    chk("R7 locked before saturation run", in_sync, 1);
    repeat (100) pay(8'h11, 1'b1);
    chk("R4 two errors per byte", err_cnt, exp_err);
    repeat (30) pay(8'h11, 1'b1);
    chk("R8 error count saturates", err_cnt, CMAX);
    repeat (120) pay(8'h00, 1'b1);
    chk("R8 byte count saturates", byte_cnt, CMAX);
    chk("R8 error count held", err_cnt, CMAX);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule